// File: doc/BRIEF.md
# Stop-Mode Wakeup Sequencer

This block steers a processor core into and out of its low-power stop state. The instruction decoder raises a stop request. The sequencer then drops the core clock enable and forces the external bus port into a safe idle condition. If the bus was granted away at that moment, it also holds the whole port floating. The sequencer then waits for one of two active-low pins. The reset pin sends the core straight into reset processing. The interrupt-request pin starts a clock-stabilization count.

An interrupt wakeup runs through three phases. The first is a stabilization count, which is long by default and short when a mode input selects it; peripherals and external interrupts are held cleared for its whole length. The second is a one-cycle re-arm, where interrupt arbitration is re-enabled. The third is a fixed settling interval. The re-arm cycle and the settling interval together last 17 cycles, and the block then pulses a resume strobe to the core. If the interrupt pin is already low when the stop request arrives, the clock enable is never dropped and the count starts at once.

Reset wins over the interrupt path at every point of the sequence. Both pins pass through a synchronizer clocked by the free-running oscillator clock.

Top module: `stopwake_top`

## Requirements
- R1: After `arstN` is released with no stop request, `coreClkEn`=1 and `busIdle`, `busFloat`, `periphClear`, `irqReenable`, `enterReset` and `resume` are all 0.
- R2: A `stopReq` high at a rising edge, with the synchronized interrupt pin inactive (high), gives `coreClkEn`=0 and `busIdle`=1 from the next cycle on. This holds until a wakeup pin is seen low.
- R3: `busFloat` takes the value of `busGrant` at the stop-entry edge. It holds that value through the whole sequence and returns to 0 in the cycle after `resume` or `enterReset`.
- R4: `resetPinN` and `irqPinN` each pass through two flops. When `irqPinN` is driven low during the halted state, `periphClear` rises on the third rising edge and `coreClkEn` returns to 1 at that same edge. With `shortDelay`=0, `periphClear` then stays high for exactly 65536 cycles.
- R5: With `shortDelay`=1 at the start of the count, `periphClear` stays high for exactly 3 cycles.
- R6: In the first cycle after `periphClear` falls, `irqReenable` is high for exactly one cycle. `resume` is high for one cycle in the 17th cycle counted from that first cycle. In the following cycle `busIdle`=0.
- R7: When `resetPinN` is driven low during the halted state, `enterReset` is high for exactly one cycle, on the second rising edge. `periphClear` stays 0, and `busIdle` is 0 in the next cycle.
- R8: A synchronized low on `resetPinN` during the stabilization count or the settling interval ends the sequence. `enterReset` pulses once, `periphClear` drops, and no `resume` follows.
- R9: If the synchronized interrupt pin is already low when `stopReq` is taken, `coreClkEn` stays 1 through the whole sequence and `periphClear` is high from the next cycle on.
- R10: `stopReq` is ignored while a sequence is in progress. It neither restarts nor lengthens the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running oscillator clock |
| arstN | input | 1 | Asynchronous active-low reset of the block itself |
| stopReq | input | 1 | Stop request from the instruction decoder |
| shortDelay | input | 1 | 1 selects the short stabilization count, 0 the long one |
| busGrant | input | 1 | External bus currently granted to another master |
| resetPinN | input | 1 | Asynchronous active-low reset wakeup pin |
| irqPinN | input | 1 | Asynchronous active-low interrupt wakeup pin |
| coreClkEn | output | 1 | Core clock enable; 0 while halted |
| busIdle | output | 1 | Bus strobes inactive, data released, address held |
| busFloat | output | 1 | Whole bus port three-stated |
| periphClear | output | 1 | Peripherals and external interrupts held cleared |
| irqReenable | output | 1 | One-cycle strobe to re-enable interrupt arbitration |
| enterReset | output | 1 | One-cycle strobe: core enters reset processing |
| resume | output | 1 | One-cycle strobe: core resumes execution |

## Verification
A control state that is off by one phase shows up at once at the ports. It appears as a wrong level of `coreClkEn`, `busIdle` or `periphClear` in the cycle after the offending edge. A counter that loads the wrong value or skips a step does not show until the end of the phase. It is seen as a `periphClear` run of the wrong length, or as a `resume` that comes in the wrong cycle after `irqReenable`. That can be up to 65536 cycles after the fault, so every phase length is measured to the exact cycle. A lost or stuck grant latch shows on `busFloat` in the first cycle of the stop. A missed reset priority shows as a `resume` that follows an `enterReset`.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_HALT,
    ST_STABILIZE,
    ST_REARM,
    ST_SETTLE
  } stopState_e;

  typedef enum logic [1:0] {
    LOAD_NONE,
    LOAD_LONG,
    LOAD_SHORT,
    LOAD_SETTLE
  } loadSel_e;

  typedef struct packed {
    loadSel_e loadSel;
    logic     dec;
    logic     captureGrant;
    logic     clearGrant;
  } ctrlStrobes_t;

endpackage

// File: rtl/stopwake_sync.sv
module stopwake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  input  logic pinN,
  output logic syncN
);

  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge arstN) begin
          if (!arstN) chain[0] <= 1'b1;
          else        chain[0] <= pinN;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge arstN) begin
          if (!arstN) chain[gi] <= 1'b1;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign syncN = chain[STAGES-1];

endmodule

// File: rtl/stopwake_datapath.sv
module stopwake_datapath
  import stopwake_pkg::*;
#(
  parameter int LONG_COUNT    = 65536,
  parameter int SHORT_COUNT   = 3,
  parameter int SETTLE_CYCLES = 17
) (
  input  logic         clk,
  input  logic         arstN,
  input  ctrlStrobes_t strobes,
  input  logic         busGrant,
  output logic         cntZero,
  output logic         grantLatch
);

  localparam int CNT_W = $clog2(LONG_COUNT + 1);
  localparam logic [CNT_W-1:0] LOAD_LONG_V   = CNT_W'(LONG_COUNT - 1);
  localparam logic [CNT_W-1:0] LOAD_SHORT_V  = CNT_W'(SHORT_COUNT - 1);
  localparam logic [CNT_W-1:0] LOAD_SETTLE_V = CNT_W'(SETTLE_CYCLES - 2);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;

  always_comb begin
    cntNext = cnt;
    unique case (strobes.loadSel)
      LOAD_LONG:   cntNext = LOAD_LONG_V;
      LOAD_SHORT:  cntNext = LOAD_SHORT_V;
      LOAD_SETTLE: cntNext = LOAD_SETTLE_V;
      default: begin
        if (strobes.dec) cntNext = cnt - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) cnt <= '0;
    else        cnt <= cntNext;
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)                    grantLatch <= 1'b0;
    else if (strobes.clearGrant)   grantLatch <= 1'b0;
    else if (strobes.captureGrant) grantLatch <= busGrant;
  end

  // R4: the control never asks for a step below zero
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!arstN)
    (strobes.dec && strobes.loadSel == LOAD_NONE) |-> (cnt != '0));

  // R3: grant latch only moves on a capture or clear strobe
  p_grant_hold_r3: assert property (@(posedge clk) disable iff (!arstN)
    (!strobes.captureGrant && !strobes.clearGrant) |=> $stable(grantLatch));

endmodule

// File: rtl/stopwake_control.sv
module stopwake_control
  import stopwake_pkg::*;
(
  input  logic         clk,
  input  logic         arstN,
  input  logic         stopReq,
  input  logic         shortDelay,
  input  logic         resetSyncN,
  input  logic         irqSyncN,
  input  logic         cntZero,
  output ctrlStrobes_t strobes,
  output logic         coreClkEn,
  output logic         busIdle,
  output logic         periphClear,
  output logic         irqReenable,
  output logic         enterReset,
  output logic         resume
);

  stopState_e state;
  stopState_e stateNext;
  loadSel_e   countSel;

  assign countSel = shortDelay ? LOAD_SHORT : LOAD_LONG;

  always_comb begin
    stateNext = state;
    strobes   = '{loadSel: LOAD_NONE, dec: 1'b0, captureGrant: 1'b0, clearGrant: 1'b0};
    enterReset = 1'b0;
    resume     = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (stopReq) begin
          strobes.captureGrant = 1'b1;
          if (!irqSyncN) begin
            strobes.loadSel = countSel;
            stateNext       = ST_STABILIZE;
          end else begin
            stateNext = ST_HALT;
          end
        end
      end
      ST_HALT: begin
        if (!resetSyncN) begin
          enterReset         = 1'b1;
          strobes.clearGrant = 1'b1;
          stateNext          = ST_RUN;
        end else if (!irqSyncN) begin
          strobes.loadSel = countSel;
          stateNext       = ST_STABILIZE;
        end
      end
      ST_STABILIZE: begin
        if (!resetSyncN) begin
          enterReset         = 1'b1;
          strobes.clearGrant = 1'b1;
          stateNext          = ST_RUN;
        end else if (cntZero) begin
          stateNext = ST_REARM;
        end else begin
          strobes.dec = 1'b1;
        end
      end
      ST_REARM: begin
        if (!resetSyncN) begin
          enterReset         = 1'b1;
          strobes.clearGrant = 1'b1;
          stateNext          = ST_RUN;
        end else begin
          strobes.loadSel = LOAD_SETTLE;
          stateNext       = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (!resetSyncN) begin
          enterReset         = 1'b1;
          strobes.clearGrant = 1'b1;
          stateNext          = ST_RUN;
        end else if (cntZero) begin
          resume             = 1'b1;
          strobes.clearGrant = 1'b1;
          stateNext          = ST_RUN;
        end else begin
          strobes.dec = 1'b1;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) state <= ST_RUN;
    else        state <= stateNext;
  end

  assign coreClkEn   = (state != ST_HALT);
  assign busIdle     = (state != ST_RUN);
  assign periphClear = (state == ST_STABILIZE);
  assign irqReenable = (state == ST_REARM);

  // R7: a reset wakeup always lands back in the running state
  p_reset_exit_r7: assert property (@(posedge clk) disable iff (!arstN)
    enterReset |=> (state == ST_RUN && !enterReset));

  // R6: resume is a single pulse followed by running
  p_resume_exit_r6: assert property (@(posedge clk) disable iff (!arstN)
    resume |=> (state == ST_RUN && !resume));

  // R6: re-arm only follows a finished stabilization count
  p_rearm_order_r6: assert property (@(posedge clk) disable iff (!arstN)
    (state == ST_REARM) |-> $past(state == ST_STABILIZE));

  // R9: stop taken with the interrupt pin low never gates the clock
  p_fast_no_gate_r9: assert property (@(posedge clk) disable iff (!arstN)
    (state == ST_RUN && stopReq && !irqSyncN) |=> (coreClkEn && periphClear));

  // R8: reset and resume never fire together
  p_reset_priority_r8: assert property (@(posedge clk) disable iff (!arstN)
    !(enterReset && resume));

endmodule

// File: rtl/stopwake_top.sv
module stopwake_top
  import stopwake_pkg::*;
#(
  parameter int LONG_COUNT    = 65536,
  parameter int SHORT_COUNT   = 3,
  parameter int SETTLE_CYCLES = 17,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic arstN,
  input  logic stopReq,
  input  logic shortDelay,
  input  logic busGrant,
  input  logic resetPinN,
  input  logic irqPinN,
  output logic coreClkEn,
  output logic busIdle,
  output logic busFloat,
  output logic periphClear,
  output logic irqReenable,
  output logic enterReset,
  output logic resume
);

  logic         resetSyncN;
  logic         irqSyncN;
  logic         cntZero;
  ctrlStrobes_t strobes;

  stopwake_sync #(.STAGES(SYNC_STAGES)) u_resetSync (
    .clk(clk), .arstN(arstN), .pinN(resetPinN), .syncN(resetSyncN)
  );

  stopwake_sync #(.STAGES(SYNC_STAGES)) u_irqSync (
    .clk(clk), .arstN(arstN), .pinN(irqPinN), .syncN(irqSyncN)
  );

  stopwake_control u_control (
    .clk(clk), .arstN(arstN), .stopReq(stopReq), .shortDelay(shortDelay),
    .resetSyncN(resetSyncN), .irqSyncN(irqSyncN), .cntZero(cntZero),
    .strobes(strobes), .coreClkEn(coreClkEn), .busIdle(busIdle),
    .periphClear(periphClear), .irqReenable(irqReenable),
    .enterReset(enterReset), .resume(resume)
  );

  stopwake_datapath #(
    .LONG_COUNT(LONG_COUNT), .SHORT_COUNT(SHORT_COUNT), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_datapath (
    .clk(clk), .arstN(arstN), .strobes(strobes), .busGrant(busGrant),
    .cntZero(cntZero), .grantLatch(busFloat)
  );

endmodule

// File: tb/stopwake_top_bench.sv
module stopwake_top_bench;

  logic clk = 1'b0;
  logic arstN = 1'b0;
  logic stopReq = 1'b0, shortDelay = 1'b0, busGrant = 1'b0;
  logic resetPinN = 1'b1, irqPinN = 1'b1;
  logic coreClkEn, busIdle, busFloat, periphClear, irqReenable, enterReset, resume;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  stopwake_top u_stopwake_top (
    .clk(clk), .arstN(arstN), .stopReq(stopReq), .shortDelay(shortDelay),
    .busGrant(busGrant), .resetPinN(resetPinN), .irqPinN(irqPinN),
    .coreClkEn(coreClkEn), .busIdle(busIdle), .busFloat(busFloat),
    .periphClear(periphClear), .irqReenable(irqReenable),
    .enterReset(enterReset), .resume(resume)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idleWait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // enter stop with interrupt pin high, checking R2/R3 on the next cycle
  task automatic enterStop(input bit grant);
    @(negedge clk);
    stopReq = 1'b1; busGrant = grant;
    @(negedge clk);
    stopReq = 1'b0; busGrant = 1'b0;
    check(coreClkEn == 1'b0, "R2 clock gated", int'(coreClkEn), 0);
    check(busIdle == 1'b1, "R2 bus idle", int'(busIdle), 1);
    check(busFloat == grant, "R3 float captured", int'(busFloat), int'(grant));
    idleWait(5);
    check(coreClkEn == 1'b0 && busIdle == 1'b1, "R2 still halted", int'(coreClkEn), 0);
  endtask

  // measure clear run, re-arm and settle after the clear starts; returns via checks
  task automatic measureWake(input int expClear, input bit grant, input string req);
    int clearLen = 0;
    int settleLen = 0;
    int reenCount = 0;
    bit floatHeld = 1'b1;
    while (periphClear && clearLen < 70000) begin
      clearLen++;
      if (busFloat != grant) floatHeld = 1'b0;
      @(negedge clk);
    end
    check(clearLen == expClear, req, clearLen, expClear);
    check(floatHeld, "R3 float held through count", 0, 1);
    check(irqReenable == 1'b1, "R6 reenable first cycle", int'(irqReenable), 1);
    while (settleLen < 40) begin
      settleLen++;
      if (irqReenable) reenCount++;
      if (resume) break;
      @(negedge clk);
    end
    check(settleLen == 17, "R6 resume cycle", settleLen, 17);
    check(reenCount == 1, "R6 reenable width", reenCount, 1);
    @(negedge clk);
    check(busIdle == 1'b0 && resume == 1'b0, "R6 running after resume", int'(busIdle), 0);
    check(busFloat == 1'b0, "R3 float released", int'(busFloat), 0);
  endtask

  task automatic t_reset_state;
    idleWait(3);
    check(coreClkEn == 1'b1 && busIdle == 1'b0 && busFloat == 1'b0 && periphClear == 1'b0
          && irqReenable == 1'b0 && enterReset == 1'b0 && resume == 1'b0,
          "R1 reset outputs", int'(busIdle), 0);
  endtask

  task automatic t_irq_wake(input bit shortMode, input bit grant);
    int lat = 0;
    shortDelay = shortMode;
    enterStop(grant);
    irqPinN = 1'b0;
    do begin
      @(negedge clk);
      lat++;
    end while (!periphClear && lat < 10);
    check(lat == 3, "R4 sync latency", lat, 3);
    check(coreClkEn == 1'b1, "R4 clock back", int'(coreClkEn), 1);
    measureWake(shortMode ? 3 : 65536, grant, shortMode ? "R5 short count" : "R4 long count");
    irqPinN = 1'b1;
    idleWait(4);
  endtask

  task automatic t_reset_wake;
    int lat = 0;
    int pulses = 0;
    int clr = 0;
    enterStop(1'b1);
    resetPinN = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (enterReset) begin pulses++; lat = i; end
      if (periphClear) clr++;
      if (i == 3) check(busIdle == 1'b0, "R7 running next cycle", int'(busIdle), 0);
      if (i == 3) check(busFloat == 1'b0, "R3 float cleared on reset", int'(busFloat), 0);
    end
    check(lat == 2, "R7 reset latency", lat, 2);
    check(pulses == 1, "R7 single pulse", pulses, 1);
    check(clr == 0, "R7 no clear", clr, 0);
    resetPinN = 1'b1;
    idleWait(4);
  endtask

  task automatic t_reset_mid(input bit inSettle);
    int pulses = 0;
    int res = 0;
    shortDelay = inSettle;
    enterStop(1'b0);
    irqPinN = 1'b0;
    if (inSettle) begin
      for (int i = 0; i < 20 && !irqReenable; i++) @(negedge clk);
      idleWait(3);
    end else begin
      idleWait(100);
    end
    resetPinN = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (enterReset) pulses++;
      if (resume) res++;
    end
    check(pulses == 1, "R8 reset aborts", pulses, 1);
    check(res == 0, "R8 no resume", res, 0);
    check(periphClear == 1'b0 && busIdle == 1'b0, "R8 running", int'(periphClear), 0);
    resetPinN = 1'b1; irqPinN = 1'b1;
    idleWait(4);
  endtask

  task automatic t_fast_path;
    int clkLow = 0;
    int clearLen = 0;
    shortDelay = 1'b1;
    irqPinN = 1'b0;
    idleWait(4);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    check(periphClear == 1'b1, "R9 count starts at once", int'(periphClear), 1);
    for (int i = 0; i < 30 && busIdle; i++) begin
      if (!coreClkEn) clkLow++;
      if (periphClear) clearLen++;
      @(negedge clk);
    end
    check(clkLow == 0, "R9 clock never gated", clkLow, 0);
    check(clearLen == 3, "R9 short count", clearLen, 3);
    irqPinN = 1'b1;
    idleWait(4);
  endtask

  task automatic t_stop_ignored;
    int lat = 0;
    shortDelay = 1'b1;
    enterStop(1'b0);
    irqPinN = 1'b0;
    do begin
      @(negedge clk);
      lat++;
    end while (!periphClear && lat < 10);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    // one clear cycle already consumed above
    measureWake(2, 1'b0, "R10 count not restarted");
    irqPinN = 1'b1;
    idleWait(4);
  endtask

  initial begin
    idleWait(3);
    arstN = 1'b1;
    t_reset_state();
    t_irq_wake(1'b1, 1'b0);
    t_irq_wake(1'b1, 1'b1);
    t_irq_wake(1'b0, 1'b1);
    t_reset_wake();
    t_reset_mid(1'b0);
    t_reset_mid(1'b1);
    t_fast_path();
    t_stop_ignored();
    finished = 1'b1;
  end

  initial begin
    for (int i = 0; i < 190000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule